// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Wait States

This block decides, at the edge of an 8-bit processor core, which pending interrupt the core should take next. It watches three inputs: an edge-sensitive non-maskable line, a fast maskable level line and a normal maskable level line. It keeps the two mask bits the core's condition codes carry, chooses the highest eligible source, and hands the core's sequencer a service descriptor. The descriptor holds the source, the stacking frame to build, the vector address and the cycle cost of the entry.

The descriptor travels on a valid/ready channel. `svc_valid` rises once a serviceable source exists. From then on the whole payload is frozen until the cycle in which `svc_ready` is also high. Back-pressure is unlimited: the sequencer may hold `svc_ready` low for any number of cycles, and the payload and the choice stay as first offered. The handshake is the moment of entry. At the handshake the block updates the mask bits, clears the non-maskable latch when that source was chosen, and leaves any wait mode.

The core parks in one of two wait modes by pulsing a request. In the any-line wait, every pending line ends the wait, whether it is masked or not. In the pre-stacked wait, the core has already saved its full state, so only an interrupt that can actually be serviced ends it, and that entry builds no new frame.

Top module: `irq_arbiter`

## Requirements
- R1: When several sources are eligible in the same cycle, the descriptor names the non-maskable source first, then the fast one, then the normal one. Source code on `svc_src`: 1 = non-maskable, 2 = fast, 3 = normal.
- R2: The vector is FFFC for the non-maskable source, FFF6 for the fast source and FFF8 for the normal source.
- R3: The non-maskable latch is set only by a 0-to-1 transition of `nmi_pin` while armed. A transition seen before arming is lost, and a line held high does not set the latch again.
- R4: A pulse on `sp_wr` arms the non-maskable input. The arming persists until reset, and reset clears it.
- R5: The non-maskable latch clears at the handshake that serves it. The level lines are never cleared by the block, so a level still held is offered again as soon as its mask is released through `cc_wr`.
- R6: The fast source is eligible only while `mask_f` is 0, and the normal source only while `mask_i` is 0.
- R7: At the handshake, a non-maskable or fast entry sets both `mask_i` and `mask_f`, while a normal entry sets only `mask_i`. A `cc_wr` pulse otherwise loads both masks from `cc_mask_i`/`cc_mask_f`, and a handshake in the same cycle takes precedence.
- R8: Outside the pre-stacked wait, `svc_frame` is 1 (full frame) with a cost of 19 cycles for the non-maskable and normal sources, and 2 (short frame) with a cost of 10 for the fast source.
- R9: Reset sets both masks, drops `svc_valid`, clears the non-maskable latch and leaves both wait modes.
- R10: In the any-line wait (`wait_any` high, one idle cycle per clock), no descriptor is offered. Any pending line ends the wait one cycle later, including a masked line.
- R11: In the pre-stacked wait, masked lines do not end the wait. A serviceable source is offered with `svc_frame` = 0 (no frame) at its usual cost, and `wait_push` falls at the handshake.
- R12: While `svc_valid` is high and `svc_ready` is low, `svc_valid` stays high and `svc_src`, `svc_frame`, `svc_vector` and `svc_cycles` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_pin | input | 1 | Non-maskable request, edge-sensitive |
| fast_pin | input | 1 | Fast maskable request, level |
| norm_pin | input | 1 | Normal maskable request, level |
| sp_wr | input | 1 | Pulse: hardware stack pointer written with a new value |
| cc_wr | input | 1 | Pulse: core loads both mask bits |
| cc_mask_i | input | 1 | Normal mask value for `cc_wr` |
| cc_mask_f | input | 1 | Fast mask value for `cc_wr` |
| wait_any_req | input | 1 | Pulse: enter the any-line wait |
| wait_push_req | input | 1 | Pulse: enter the pre-stacked wait |
| svc_valid | output | 1 | Descriptor offered |
| svc_ready | input | 1 | Sequencer accepts the descriptor |
| svc_src | output | 2 | Chosen source (1 non-maskable, 2 fast, 3 normal) |
| svc_frame | output | 2 | Frame to stack (0 none, 1 full, 2 short) |
| svc_vector | output | VEC_W | Vector address to fetch |
| svc_cycles | output | CYC_W | Cycle cost of the entry |
| mask_i | output | 1 | Current normal mask |
| mask_f | output | 1 | Current fast mask |
| wait_any | output | 1 | Any-line wait active |
| wait_push | output | 1 | Pre-stacked wait active |

## Verification
The main function is exercised in several ways. The three lines are held together while masked and then released in one cycle, and after each entry only the masks are reopened, so the result shows the priority order rather than the arrival order. A single held normal line is served, masked by its own entry and served again after a mask write; this separates level sources from the one-shot non-maskable latch. Non-maskable edges are sent before arming, while the line is held high, and after a reset, which checks that each of these is ignored. Each wait mode is fed a masked line and then a serviceable one: the any-line wait must end on the masked line, and the pre-stacked wait must not.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_FAST = 2'd2,
    SRC_NORM = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    FRM_NONE  = 2'd0,
    FRM_FULL  = 2'd1,
    FRM_SHORT = 2'd2
  } frame_e;
endpackage

// File: rtl/nmi_gate.sv
module nmi_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic arm_evt,
  input  logic clr,
  output logic armed,
  output logic pend
);
  logic pin_q;
  logic rise;

  assign rise = pin & ~pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      armed <= 1'b0;
      pend  <= 1'b0;
    end else begin
      pin_q <= pin;
      if (arm_evt) armed <= 1'b1;
      if (rise && armed) pend <= 1'b1;
      else if (clr)      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import irq_arb_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter int CYC_W = 5,
  parameter logic [VEC_W-1:0] VEC_NMI  = 16'hFFFC,
  parameter logic [VEC_W-1:0] VEC_FAST = 16'hFFF6,
  parameter logic [VEC_W-1:0] VEC_NORM = 16'hFFF8,
  parameter int CYC_FULL  = 19,
  parameter int CYC_SHORT = 10
) (
  input  logic             nmi_pend,
  input  logic             fast_lvl,
  input  logic             norm_lvl,
  input  logic             mask_f,
  input  logic             mask_i,
  output logic             hit,
  output logic [1:0]       src,
  output logic [VEC_W-1:0] vector,
  output logic [CYC_W-1:0] cycles,
  output logic             short_frame
);
  localparam logic [VEC_W-1:0] VEC_TBL [NSRC] = '{VEC_NMI, VEC_FAST, VEC_NORM};
  localparam logic [CYC_W-1:0] CYC_TBL [NSRC] =
    '{CYC_W'(CYC_FULL), CYC_W'(CYC_SHORT), CYC_W'(CYC_FULL)};
  localparam logic [NSRC-1:0] SHORT_SET = 3'b010;

  logic [NSRC-1:0] req;
  logic [NSRC-1:0] blk;
  logic [NSRC-1:0] elig;
  logic [1:0]      sel;

  assign req = {norm_lvl, fast_lvl, nmi_pend};
  assign blk = {mask_i, mask_f, 1'b0};

  generate
    for (genvar k = 0; k < NSRC; k++) begin : g_elig
      assign elig[k] = req[k] & ~blk[k];
    end
  endgenerate

  always_comb begin
    sel = 2'd0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (elig[k]) sel = 2'(k);
    end
  end

  assign hit         = |elig;
  assign src         = hit ? (sel + 2'd1) : SRC_NONE;
  assign vector      = VEC_TBL[sel];
  assign cycles      = CYC_TBL[sel];
  assign short_frame = SHORT_SET[sel];
endmodule

// File: rtl/wait_ctrl.sv
module wait_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic any_req,
  input  logic push_req,
  input  logic can_enter,
  input  logic any_line,
  input  logic accept,
  output logic wait_any,
  output logic wait_push
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_any  <= 1'b0;
      wait_push <= 1'b0;
    end else begin
      if (wait_any && any_line)
        wait_any <= 1'b0;
      else if (any_req && !push_req && can_enter && !wait_push)
        wait_any <= 1'b1;

      if (accept)
        wait_push <= 1'b0;
      else if (push_req && can_enter && !wait_any)
        wait_push <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter int CYC_W = 5,
  parameter logic [VEC_W-1:0] VEC_NMI  = 16'hFFFC,
  parameter logic [VEC_W-1:0] VEC_FAST = 16'hFFF6,
  parameter logic [VEC_W-1:0] VEC_NORM = 16'hFFF8,
  parameter int CYC_FULL  = 19,
  parameter int CYC_SHORT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_pin,
  input  logic             fast_pin,
  input  logic             norm_pin,
  input  logic             sp_wr,
  input  logic             cc_wr,
  input  logic             cc_mask_i,
  input  logic             cc_mask_f,
  input  logic             wait_any_req,
  input  logic             wait_push_req,
  output logic             svc_valid,
  input  logic             svc_ready,
  output logic [1:0]       svc_src,
  output logic [1:0]       svc_frame,
  output logic [VEC_W-1:0] svc_vector,
  output logic [CYC_W-1:0] svc_cycles,
  output logic             mask_i,
  output logic             mask_f,
  output logic             wait_any,
  output logic             wait_push
);
  logic             nmi_armed;
  logic             nmi_pend;
  logic             hs;
  logic             hit;
  logic [1:0]       pick_src;
  logic [VEC_W-1:0] pick_vec;
  logic [CYC_W-1:0] pick_cyc;
  logic             pick_short;
  logic             any_line;
  logic             raise;

  assign hs       = svc_valid & svc_ready;
  assign any_line = nmi_pend | fast_pin | norm_pin;
  assign raise    = !svc_valid && hit && !wait_any && !wait_any_req && !wait_push_req;

  nmi_gate u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (nmi_pin),
    .arm_evt (sp_wr),
    .clr     (hs && (svc_src == SRC_NMI)),
    .armed   (nmi_armed),
    .pend    (nmi_pend)
  );

  irq_prio #(
    .VEC_W     (VEC_W),
    .CYC_W     (CYC_W),
    .VEC_NMI   (VEC_NMI),
    .VEC_FAST  (VEC_FAST),
    .VEC_NORM  (VEC_NORM),
    .CYC_FULL  (CYC_FULL),
    .CYC_SHORT (CYC_SHORT)
  ) u_prio (
    .nmi_pend    (nmi_pend),
    .fast_lvl    (fast_pin),
    .norm_lvl    (norm_pin),
    .mask_f      (mask_f),
    .mask_i      (mask_i),
    .hit         (hit),
    .src         (pick_src),
    .vector      (pick_vec),
    .cycles      (pick_cyc),
    .short_frame (pick_short)
  );

  wait_ctrl u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_req   (wait_any_req),
    .push_req  (wait_push_req),
    .can_enter (!svc_valid),
    .any_line  (any_line),
    .accept    (hs),
    .wait_any  (wait_any),
    .wait_push (wait_push)
  );

  // Mask bits: entry sets them, a core write loads them.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_i <= 1'b1;
      mask_f <= 1'b1;
    end else if (hs) begin
      mask_i <= 1'b1;
      if (svc_src != SRC_NORM) mask_f <= 1'b1;
    end else if (cc_wr) begin
      mask_i <= cc_mask_i;
      mask_f <= cc_mask_f;
    end
  end

  // Descriptor register: captured on raise, frozen until the handshake.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_valid  <= 1'b0;
      svc_src    <= SRC_NONE;
      svc_frame  <= FRM_NONE;
      svc_vector <= '0;
      svc_cycles <= '0;
    end else if (hs) begin
      svc_valid <= 1'b0;
    end else if (raise) begin
      svc_valid  <= 1'b1;
      svc_src    <= pick_src;
      svc_vector <= pick_vec;
      svc_cycles <= pick_cyc;
      if (wait_push)       svc_frame <= FRM_NONE;
      else if (pick_short) svc_frame <= FRM_SHORT;
      else                 svc_frame <= FRM_FULL;
    end
  end

  logic unused_ok;
  assign unused_ok = nmi_armed;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int VEC_W = 16,
  parameter int CYC_W = 5,
  parameter logic [VEC_W-1:0] VEC_NMI  = 16'hFFFC,
  parameter logic [VEC_W-1:0] VEC_FAST = 16'hFFF6,
  parameter int CYC_FULL  = 19,
  parameter int CYC_SHORT = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             svc_valid,
  input logic             svc_ready,
  input logic [1:0]       svc_src,
  input logic [1:0]       svc_frame,
  input logic [VEC_W-1:0] svc_vector,
  input logic [CYC_W-1:0] svc_cycles,
  input logic             mask_i,
  input logic             mask_f,
  input logic             wait_any,
  input logic             wait_push
);
  // R12
  payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && !svc_ready |=> svc_valid && $stable(svc_src) && $stable(svc_frame)
      && $stable(svc_vector) && $stable(svc_cycles));

  // R10
  no_offer_in_any_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_any |-> !svc_valid);

  // R2
  nmi_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && svc_src == 2'd1 |-> svc_vector == VEC_NMI && svc_cycles == CYC_W'(CYC_FULL));

  // R8
  fast_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && svc_src == 2'd2 && !wait_push |->
      svc_frame == 2'd2 && svc_cycles == CYC_W'(CYC_SHORT) && svc_vector == VEC_FAST);

  // R11
  prestacked_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && wait_push |-> svc_frame == 2'd0);

  // R7
  norm_entry_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && svc_ready && svc_src == 2'd3 |=> mask_i);

  // R7
  hi_entry_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && svc_ready && svc_src != 2'd3 |=> mask_i && mask_f);

  // R6
  fast_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_valid) && svc_src == 2'd2 |-> !$past(mask_f));

  // R6
  norm_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_valid) && svc_src == 2'd3 |-> !$past(mask_i));
endmodule

bind irq_arbiter irq_arbiter_chk #(
  .VEC_W     (VEC_W),
  .CYC_W     (CYC_W),
  .VEC_NMI   (VEC_NMI),
  .VEC_FAST  (VEC_FAST),
  .CYC_FULL  (CYC_FULL),
  .CYC_SHORT (CYC_SHORT)
) u_chk (.*);

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_pin = 0, fast_pin = 0, norm_pin = 0, sp_wr = 0;
  logic cc_wr = 0, cc_mask_i = 1, cc_mask_f = 1;
  logic wait_any_req = 0, wait_push_req = 0, svc_ready = 1;
  logic svc_valid, mask_i, mask_f, wait_any, wait_push;
  logic [1:0] svc_src, svc_frame;
  logic [15:0] svc_vector;
  logic [4:0] svc_cycles;

  int checks = 0;
  int errors = 0;
  logic [24:0] exp_q[$];
  string exp_tag[$];

  always #10 clk = ~clk;

  irq_arbiter u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // driver side of the scoreboard: src, frame, cycles, vector
  task automatic expect_item(string tag, logic [1:0] s, logic [1:0] f, logic [4:0] c, logic [15:0] v);
    exp_q.push_back({s, f, c, v});
    exp_tag.push_back(tag);
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) tick(1);
    chk({tag, " descriptor delivered"}, exp_q.size(), 0);
    tick(2);
  endtask

  task automatic set_masks(logic i, logic f);
    cc_mask_i = i; cc_mask_f = f; cc_wr = 1; tick(1); cc_wr = 0;
  endtask

  // monitor side: compare at each handshake
  always @(negedge clk) begin
    if (rst_n && svc_valid && svc_ready) begin
      if (exp_q.size() == 0) begin
        chk("unexpected descriptor", {7'd0, svc_src, svc_frame, svc_cycles, svc_vector}, 32'd0);
      end else begin
        logic [24:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        chk(t, {7'd0, svc_src, svc_frame, svc_cycles, svc_vector}, {7'd0, e});
      end
    end
  end

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R9 reset state
    chk("R9 mask_i after reset", mask_i, 1);
    chk("R9 mask_f after reset", mask_f, 1);
    chk("R9 no offer after reset", svc_valid, 0);
    chk("R9 no wait after reset", {wait_any, wait_push}, 0);

    // R3 edge before arming is lost
    nmi_pin = 1; tick(5);
    chk("R3 unarmed edge ignored", svc_valid, 0);
    nmi_pin = 0; tick(2);
    // R4 arm, then an edge is taken
    sp_wr = 1; tick(1); sp_wr = 0; tick(3);
    chk("R4 arming alone offers nothing", svc_valid, 0);
    expect_item("R2 R4 nmi entry", 2'd1, 2'd1, 5'd19, 16'hFFFC);
    nmi_pin = 1;
    drain("R4 nmi");
    tick(4);
    chk("R3 held nmi level not retaken", svc_valid, 0);
    chk("R7 nmi entry sets mask_f", mask_f, 1);
    nmi_pin = 0; tick(2);

    // R6 masked normal line, R5 re-offer after unmasking
    norm_pin = 1; tick(5);
    chk("R6 masked normal line ignored", svc_valid, 0);
    expect_item("R2 R8 normal entry", 2'd3, 2'd1, 5'd19, 16'hFFF8);
    set_masks(0, 0);
    drain("R6 normal");
    chk("R7 normal entry sets mask_i", mask_i, 1);
    chk("R7 normal entry leaves mask_f", mask_f, 0);
    tick(4);
    chk("R5 held line waits for mask", svc_valid, 0);
    expect_item("R5 level retaken", 2'd3, 2'd1, 5'd19, 16'hFFF8);
    set_masks(0, 0);
    drain("R5 normal");
    norm_pin = 0;
    set_masks(1, 1);

    // R1 priority with all three eligible together, R12 back-pressure
    fast_pin = 1; norm_pin = 1; tick(3);
    chk("R6 masked fast and normal ignored", svc_valid, 0);
    svc_ready = 0;
    expect_item("R1 nmi first", 2'd1, 2'd1, 5'd19, 16'hFFFC);
    nmi_pin = 1; cc_mask_i = 0; cc_mask_f = 0; cc_wr = 1; tick(1); cc_wr = 0;
    tick(3);
    chk("R12 offer raised under back-pressure", svc_valid, 1);
    tick(4);
    chk("R12 offer held with source", {svc_valid, svc_src}, {1'b1, 2'd1});
    svc_ready = 1;
    drain("R1 nmi");
    chk("R7 masks set after nmi", {mask_i, mask_f}, 2'b11);
    nmi_pin = 0;
    expect_item("R1 fast before normal", 2'd2, 2'd2, 5'd10, 16'hFFF6);
    set_masks(0, 0);
    drain("R1 fast");
    chk("R7 fast entry sets both masks", {mask_i, mask_f}, 2'b11);
    expect_item("R1 normal last", 2'd3, 2'd1, 5'd19, 16'hFFF8);
    set_masks(0, 1);
    drain("R1 normal");
    fast_pin = 0; norm_pin = 0; tick(2);

    // R10 any-line wait
    wait_any_req = 1; tick(1); wait_any_req = 0; tick(3);
    chk("R10 any-line wait entered", {wait_any, svc_valid}, 2'b10);
    norm_pin = 1; tick(3);
    chk("R10 masked line ends wait", {wait_any, svc_valid}, 2'b00);
    norm_pin = 0; tick(2);
    set_masks(1, 0);
    wait_any_req = 1; tick(1); wait_any_req = 0; tick(3);
    chk("R10 wait entered again", wait_any, 1);
    expect_item("R10 fast after wait", 2'd2, 2'd2, 5'd10, 16'hFFF6);
    fast_pin = 1;
    drain("R10 fast");
    fast_pin = 0; tick(2);

    // R11 pre-stacked wait
    wait_push_req = 1; tick(1); wait_push_req = 0; tick(2);
    chk("R11 pre-stacked wait entered", wait_push, 1);
    norm_pin = 1; tick(5);
    chk("R11 masked line keeps wait", {wait_push, svc_valid}, 2'b10);
    expect_item("R11 normal no frame", 2'd3, 2'd0, 5'd19, 16'hFFF8);
    set_masks(0, 1);
    drain("R11 normal");
    chk("R11 wait left at handshake", wait_push, 0);
    norm_pin = 0; tick(2);
    wait_push_req = 1; tick(1); wait_push_req = 0; tick(2);
    expect_item("R11 nmi no frame", 2'd1, 2'd0, 5'd19, 16'hFFFC);
    nmi_pin = 1;
    drain("R11 nmi");
    chk("R11 wait left after nmi", wait_push, 0);
    nmi_pin = 0; tick(2);

    // R9 R4 reset in the middle of a wait
    set_masks(0, 0);
    wait_push_req = 1; tick(1); wait_push_req = 0; tick(2);
    rst_n = 0; tick(2); rst_n = 1; tick(2);
    chk("R9 reset leaves wait", wait_push, 0);
    chk("R9 reset sets masks", {mask_i, mask_f}, 2'b11);
    nmi_pin = 1; tick(5);
    chk("R4 reset disarms nmi", svc_valid, 0);
    nmi_pin = 0; tick(2);

    chk("scoreboard empty at end", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule